// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block walks a DMA channel through its buffer, one element address at a time. A transfer is described by a base address, an inner (row) element count with a signed inner step, and an outer (row) count with a signed outer step. Inside a row the address moves by the inner step. After the last element of a row it moves by the outer step instead. The outer step may be negative or smaller than the inner step, so an interleaved stream can be split into its component streams while it is read. Steps are counted in elements, and the element is 1, 2 or 4 bytes wide.

The transfer parameters live in a small shadow register set. Software fills it one register at a time through a write port and then raises `start`. Alternatively, a descriptor presents every parameter in parallel and launches the transfer in the same cycle. The consumer takes one address per `adv` handshake. In linear mode the block stops after the final element. In circular mode it reloads and runs again without a gap. It can flag every row end, every buffer end, or both.

Top module: `dma2d_agen`

## Requirements
- R1: During and after reset, `busy_o`, `irq_row_o`, `irq_buf_o` and `done_o` are 0.
- R2: When `start` or `dsc_load` is seen while idle, in the next cycle `busy_o` is 1 and `addr_o` equals the base address. A descriptor takes priority over the shadow registers.
- R3: A handshake (`busy_o` and `adv`) on an element that is not the last of its row adds the 16-bit two's-complement inner step, scaled by the element size, to `addr_o`. The size code is mode bits [5:4]: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R4: A handshake on the last element of a row that is not the last row adds the scaled signed outer step instead of the inner step.
- R5: A count field value of 0 means 65536 elements.
- R6: With mode bit 0 clear (1D), the outer count and outer step are ignored. The transfer is a single row of inner-count elements.
- R7: With mode bit 1 clear (linear), `done_o` is 1 exactly in the handshake cycle of the final element, and `busy_o` is 0 in the next cycle.
- R8: With mode bit 1 set (circular), the handshake on the final element returns `addr_o` to the base address, reloads both counts and keeps `busy_o` at 1. `done_o` stays 0.
- R9: With mode bit 2 set, `irq_row_o` is 1 exactly in the handshake cycle of the last element of each row.
- R10: With mode bit 3 set, `irq_buf_o` is 1 exactly in the handshake cycle of the final element of the buffer. This holds in both linear and circular mode.
- R11: `start` and `dsc_load` while busy are ignored. The address sequence continues unchanged, and the ignored descriptor does not alter the shadow registers.
- R12: While busy and `adv` is 0, `addr_o` holds and no flag is raised.
- R13: Register write port selectors: 0 base, 1 inner count, 2 inner step, 3 outer count, 4 outer step, 5 mode. Writes land in the shadow set and take effect at the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Shadow register write strobe |
| reg_sel | input | 3 | Shadow register selector |
| reg_wdata | input | AW | Shadow register write data |
| start | input | 1 | Launch from shadow registers |
| dsc_load | input | 1 | Load descriptor into shadow set and launch |
| dsc_base | input | AW | Descriptor base address |
| dsc_icnt | input | CW | Descriptor inner count |
| dsc_istep | input | SW | Descriptor inner step (signed) |
| dsc_ocnt | input | CW | Descriptor outer count |
| dsc_ostep | input | SW | Descriptor outer step (signed) |
| dsc_mode | input | 6 | Descriptor mode bits |
| adv | input | 1 | Consumer took the current address |
| addr_o | output | AW | Current element address, valid while busy |
| busy_o | output | 1 | Transfer in progress |
| irq_row_o | output | 1 | Row-end interrupt pulse |
| irq_buf_o | output | 1 | Buffer-end interrupt pulse |
| done_o | output | 1 | Final element of a linear transfer taken |

## Verification
Two things can land in the same cycle: a launch request (`start` together with a full descriptor on `dsc_load`) and the element handshake of an active transfer. The bench injects both at a chosen element index. It then checks that every following address and flag still matches the sequence expected from the original parameters. After the transfer ends, a plain `start` must restart from the original base, which shows that the descriptor was dropped rather than latched. Row-end and buffer-end flags also coincide on the last element. Each is predicted separately from its enable bit and compared at the port.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [2:0] {
    SEL_BASE  = 3'd0,
    SEL_ICNT  = 3'd1,
    SEL_ISTEP = 3'd2,
    SEL_OCNT  = 3'd3,
    SEL_OSTEP = 3'd4,
    SEL_MODE  = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] esize;    // 0:1B 1:2B 2,3:4B
    logic       buf_irq;
    logic       row_irq;
    logic       circ;
    logic       two_d;
  } mode_t;

  function automatic logic [1:0] size_shift(input logic [1:0] esize);
    case (esize)
      2'd0:    size_shift = 2'd0;
      2'd1:    size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          dsc_take,
  input  logic [AW-1:0] dsc_base,
  input  logic [CW-1:0] dsc_icnt,
  input  logic [SW-1:0] dsc_istep,
  input  logic [CW-1:0] dsc_ocnt,
  input  logic [SW-1:0] dsc_ostep,
  input  mode_t         dsc_mode,
  output logic [AW-1:0] base_o,
  output logic [CW-1:0] icnt_o,
  output logic [SW-1:0] istep_o,
  output logic [CW-1:0] ocnt_o,
  output logic [SW-1:0] ostep_o,
  output mode_t         mode_o
);

  logic [AW-1:0] base_q,  base_d;
  logic [CW-1:0] icnt_q,  icnt_d;
  logic [SW-1:0] istep_q, istep_d;
  logic [CW-1:0] ocnt_q,  ocnt_d;
  logic [SW-1:0] ostep_q, ostep_d;
  mode_t         mode_q,  mode_d;
  logic          wr_en;

  assign wr_en = dsc_take | reg_we;

  always_comb begin
    base_d  = base_q;
    icnt_d  = icnt_q;
    istep_d = istep_q;
    ocnt_d  = ocnt_q;
    ostep_d = ostep_q;
    mode_d  = mode_q;
    if (dsc_take) begin
      base_d  = dsc_base;
      icnt_d  = dsc_icnt;
      istep_d = dsc_istep;
      ocnt_d  = dsc_ocnt;
      ostep_d = dsc_ostep;
      mode_d  = dsc_mode;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_BASE:  base_d  = reg_wdata;
        SEL_ICNT:  icnt_d  = reg_wdata[CW-1:0];
        SEL_ISTEP: istep_d = reg_wdata[SW-1:0];
        SEL_OCNT:  ocnt_d  = reg_wdata[CW-1:0];
        SEL_OSTEP: ostep_d = reg_wdata[SW-1:0];
        SEL_MODE:  mode_d  = mode_t'(reg_wdata[5:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      icnt_q  <= '0;
      istep_q <= '0;
      ocnt_q  <= '0;
      ostep_q <= '0;
      mode_q  <= '0;
    end else if (wr_en) begin
      base_q  <= base_d;
      icnt_q  <= icnt_d;
      istep_q <= istep_d;
      ocnt_q  <= ocnt_d;
      ostep_q <= ostep_d;
      mode_q  <= mode_d;
    end
  end

  assign base_o  = base_q;
  assign icnt_o  = icnt_q;
  assign istep_o = istep_q;
  assign ocnt_o  = ocnt_q;
  assign ostep_o = ostep_q;
  assign mode_o  = mode_q;

  p_desc_fills_shadow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_take |=> (base_q == $past(dsc_base)) && (icnt_q == $past(dsc_icnt)));

endmodule

// File: rtl/dma2d_walk.sv
module dma2d_walk
  import dma2d_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          adv,
  input  logic [CW-1:0] icnt_i,
  input  logic [CW-1:0] ocnt_i,
  input  mode_t         mode_i,
  output logic          busy_o,
  output logic          take_o,
  output logic          outer_o,
  output logic          wrap_o,
  output logic          irq_row_o,
  output logic          irq_buf_o,
  output logic          done_o
);

  // remaining counts are stored minus one, so a field of 0 wraps to the maximum
  logic          busy_q, busy_d;
  logic [CW-1:0] irem_q, irem_d;
  logic [CW-1:0] orem_q, orem_d;
  logic [CW-1:0] irel_q, irel_d;
  logic [CW-1:0] orel_q, orel_d;
  mode_t         mode_q, mode_d;
  logic          st_en;
  logic          hs, last_col, last_row, row_end, buf_end;

  assign hs       = busy_q & adv;
  assign last_col = (irem_q == '0);
  assign last_row = (orem_q == '0);
  assign row_end  = hs & last_col;
  assign buf_end  = row_end & last_row;
  assign st_en    = launch | hs;

  always_comb begin
    busy_d = busy_q;
    irem_d = irem_q;
    orem_d = orem_q;
    irel_d = irel_q;
    orel_d = orel_q;
    mode_d = mode_q;
    if (launch) begin
      busy_d = 1'b1;
      irel_d = icnt_i - 1'b1;
      orel_d = mode_i.two_d ? (ocnt_i - 1'b1) : '0;
      irem_d = icnt_i - 1'b1;
      orem_d = mode_i.two_d ? (ocnt_i - 1'b1) : '0;
      mode_d = mode_i;
    end else if (hs) begin
      if (!last_col) begin
        irem_d = irem_q - 1'b1;
      end else if (!last_row) begin
        irem_d = irel_q;
        orem_d = orem_q - 1'b1;
      end else if (mode_q.circ) begin
        irem_d = irel_q;
        orem_d = orel_q;
      end else begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irem_q <= '0;
      orem_q <= '0;
      irel_q <= '0;
      orel_q <= '0;
      mode_q <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      irem_q <= irem_d;
      orem_q <= orem_d;
      irel_q <= irel_d;
      orel_q <= orel_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o    = busy_q;
  assign take_o    = hs;
  assign outer_o   = row_end & ~last_row;
  assign wrap_o    = buf_end & mode_q.circ;
  assign irq_row_o = row_end & mode_q.row_irq;
  assign irq_buf_o = buf_end & mode_q.buf_irq;
  assign done_o    = buf_end & ~mode_q.circ;

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  p_circ_keeps_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> busy_o && (irem_q == irel_q) && (orem_q == orel_q));

  p_stall_holds_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !adv) |=> $stable(irem_q) && $stable(orem_q) && busy_o);

  p_row_flag_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_row_o && !buf_end) |=> !irq_row_o || (irel_q == '0));

endmodule

// File: rtl/dma2d_addr.sv
module dma2d_addr
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          busy,
  input  logic          take,
  input  logic          outer,
  input  logic          wrap,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] istep_i,
  input  logic [SW-1:0] ostep_i,
  input  logic [1:0]    esize_i,
  output logic [AW-1:0] addr_o
);

  localparam int XW = AW - SW;

  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] istp_q, istp_d;
  logic [AW-1:0] ostp_q, ostp_d;
  logic [1:0]    sh;
  logic          en;

  assign sh = size_shift(esize_i);
  assign en = launch | take;

  always_comb begin
    addr_d = addr_q;
    base_d = base_q;
    istp_d = istp_q;
    ostp_d = ostp_q;
    if (launch) begin
      addr_d = base_i;
      base_d = base_i;
      istp_d = {{XW{istep_i[SW-1]}}, istep_i} << sh;
      ostp_d = {{XW{ostep_i[SW-1]}}, ostep_i} << sh;
    end else if (take) begin
      if (wrap)       addr_d = base_q;
      else if (outer) addr_d = addr_q + ostp_q;
      else            addr_d = addr_q + istp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      base_q <= '0;
      istp_q <= '0;
      ostp_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      base_q <= base_d;
      istp_q <= istp_d;
      ostp_q <= ostp_d;
    end
  end

  assign addr_o = addr_q;

  p_launch_at_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> addr_o == $past(base_i));

  p_wrap_to_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wrap) |=> addr_o == base_q);

  p_hold_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take && !launch) |=> $stable(addr_o));

endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          start,
  input  logic          dsc_load,
  input  logic [AW-1:0] dsc_base,
  input  logic [CW-1:0] dsc_icnt,
  input  logic [SW-1:0] dsc_istep,
  input  logic [CW-1:0] dsc_ocnt,
  input  logic [SW-1:0] dsc_ostep,
  input  logic [5:0]    dsc_mode,
  input  logic          adv,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          irq_row_o,
  output logic          irq_buf_o,
  output logic          done_o
);

  logic [AW-1:0] sh_base, src_base;
  logic [CW-1:0] sh_icnt, sh_ocnt, src_icnt, src_ocnt;
  logic [SW-1:0] sh_istep, sh_ostep, src_istep, src_ostep;
  mode_t         sh_mode, src_mode;
  logic          busy, launch, dsc_take;
  logic          take, outer, wrap;

  assign launch   = ~busy & (start | dsc_load);
  assign dsc_take = ~busy & dsc_load;

  // a descriptor launches from its own fields, not yet visible in the shadow set
  always_comb begin
    if (dsc_load) begin
      src_base  = dsc_base;
      src_icnt  = dsc_icnt;
      src_istep = dsc_istep;
      src_ocnt  = dsc_ocnt;
      src_ostep = dsc_ostep;
      src_mode  = mode_t'(dsc_mode);
    end else begin
      src_base  = sh_base;
      src_icnt  = sh_icnt;
      src_istep = sh_istep;
      src_ocnt  = sh_ocnt;
      src_ostep = sh_ostep;
      src_mode  = sh_mode;
    end
  end

  dma2d_regs #(.AW(AW), .CW(CW), .SW(SW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .dsc_take  (dsc_take),
    .dsc_base  (dsc_base),
    .dsc_icnt  (dsc_icnt),
    .dsc_istep (dsc_istep),
    .dsc_ocnt  (dsc_ocnt),
    .dsc_ostep (dsc_ostep),
    .dsc_mode  (mode_t'(dsc_mode)),
    .base_o    (sh_base),
    .icnt_o    (sh_icnt),
    .istep_o   (sh_istep),
    .ocnt_o    (sh_ocnt),
    .ostep_o   (sh_ostep),
    .mode_o    (sh_mode)
  );

  dma2d_walk #(.CW(CW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .adv       (adv),
    .icnt_i    (src_icnt),
    .ocnt_i    (src_ocnt),
    .mode_i    (src_mode),
    .busy_o    (busy),
    .take_o    (take),
    .outer_o   (outer),
    .wrap_o    (wrap),
    .irq_row_o (irq_row_o),
    .irq_buf_o (irq_buf_o),
    .done_o    (done_o)
  );

  dma2d_addr #(.AW(AW), .SW(SW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .busy    (busy),
    .take    (take),
    .outer   (outer),
    .wrap    (wrap),
    .base_i  (src_base),
    .istep_i (src_istep),
    .ostep_i (src_ostep),
    .esize_i (src_mode.esize),
    .addr_o  (addr_o)
  );

  assign busy_o = busy;

  p_relaunch_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (start || dsc_load) && !adv) |=> busy_o && $stable(addr_o));

  p_idle_no_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !irq_row_o && !irq_buf_o && !done_o);

endmodule

// File: tb/dma2d_agen_bench.sv
module dma2d_agen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, start, dsc_load, adv;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, dsc_base, addr_o;
  logic [15:0] dsc_icnt, dsc_istep, dsc_ocnt, dsc_ostep;
  logic [5:0]  dsc_mode;
  logic        busy_o, irq_row_o, irq_buf_o, done_o;

  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  dma2d_agen u_dma2d_agen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .start(start), .dsc_load(dsc_load),
    .dsc_base(dsc_base), .dsc_icnt(dsc_icnt), .dsc_istep(dsc_istep),
    .dsc_ocnt(dsc_ocnt), .dsc_ostep(dsc_ostep), .dsc_mode(dsc_mode),
    .adv(adv), .addr_o(addr_o), .busy_o(busy_o), .irq_row_o(irq_row_o),
    .irq_buf_o(irq_buf_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] b,
      input logic [15:0] is, input logic [15:0] os, input int cols,
      input int sh, input int r, input int c);
    longint si, so, off;
    si  = longint'($signed(is));
    so  = longint'($signed(os));
    off = (longint'(r) * (longint'(cols - 1) * si + so) + longint'(c) * si) <<< sh;
    return b + off[31:0];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 0; start = 0; dsc_load = 0; adv = 0;
    reg_sel = '0; reg_wdata = '0; dsc_base = '0; dsc_icnt = '0;
    dsc_istep = '0; dsc_ocnt = '0; dsc_ostep = '0; dsc_mode = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy_o == 0 && done_o == 0 && irq_row_o == 0 && irq_buf_o == 0,
        "R1 reset quiet", {28'd0, busy_o, done_o, irq_row_o, irq_buf_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  // R3 R4 R6 R7 R8 R9 R10 R12 checked element by element
  task automatic run(input logic [31:0] base, input logic [15:0] ic,
      input logic [15:0] is, input logic [15:0] oc, input logic [15:0] os,
      input logic [5:0] md, input bit via_desc, input int dens,
      input int passes, input int poke_at);
    int cols, rows, sh, n;
    bit taken, lc, lst;
    logic [31:0] e;
    string tag;
    cols = (ic == 0) ? 65536 : int'(ic);
    rows = md[0] ? ((oc == 0) ? 65536 : int'(oc)) : 1;
    sh   = (md[5:4] == 2'd0) ? 0 : (md[5:4] == 2'd1) ? 1 : 2;
    n    = 0;
    if (via_desc) begin
      @(negedge clk);
      dsc_base = base; dsc_icnt = ic; dsc_istep = is; dsc_ocnt = oc;
      dsc_ostep = os; dsc_mode = md; dsc_load = 1;
      @(negedge clk);
      dsc_load = 0;
    end else begin
      wr(3'd0, base); wr(3'd1, {16'd0, ic}); wr(3'd2, {16'd0, is});
      wr(3'd3, {16'd0, oc}); wr(3'd4, {16'd0, os}); wr(3'd5, {26'd0, md});
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end
    #1;
    chk(busy_o == 1, via_desc ? "R2 busy after descriptor" : "R13 busy after start",
        {31'd0, busy_o}, 32'd1);
    chk(addr_o == base, "R2 first address", addr_o, base);
    for (int p = 0; p < passes; p++) begin
      for (int r = 0; r < rows; r++) begin
        for (int c = 0; c < cols; c++) begin
          e = exp_addr(base, is, os, cols, sh, r, c);
          if (c > 0)      tag = "R3 inner step";
          else if (r > 0) tag = "R4 outer step";
          else if (p > 0) tag = "R8 circular wrap";
          else            tag = "R2 base";
          lc  = (c == cols - 1);
          lst = lc && (r == rows - 1);
          taken = 0;
          while (!taken) begin
            taken = (int'($urandom_range(99)) < dens) || (n == poke_at);
            adv = taken;
            if (taken && n == poke_at) begin
              start = 1; dsc_load = 1; dsc_base = ~base; dsc_icnt = ic + 16'd3;
              dsc_istep = is + 16'd5;
            end
            #1;
            chk(busy_o == 1, "R8/R7 busy during transfer", {31'd0, busy_o}, 32'd1);
            chk(addr_o == e, taken ? tag : "R12 hold address", addr_o, e);
            chk(irq_row_o == (taken && lc && md[2]), "R9 row flag",
                {31'd0, irq_row_o}, {31'd0, taken && lc && md[2]});
            chk(irq_buf_o == (taken && lst && md[3]), "R10 buffer flag",
                {31'd0, irq_buf_o}, {31'd0, taken && lst && md[3]});
            chk(done_o == (taken && lst && !md[1]), "R7 done flag",
                {31'd0, done_o}, {31'd0, taken && lst && !md[1]});
            @(negedge clk);
            start = 0; dsc_load = 0;
          end
          n++;
        end
      end
    end
    adv = 0;
    #1;
    if (!md[1]) chk(busy_o == 0, "R7 idle after last", {31'd0, busy_o}, 32'd0);
    else        chk(busy_o == 1, "R8 still busy", {31'd0, busy_o}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2d0a));
    do_reset();

    // 2D de-interleave: 3 rows of 4, step 3, negative outer step, 1 byte
    run(32'h0000_1000, 16'd4, 16'd3, 16'd3, 16'hFFF8, 6'b00_1101, 0, 60, 1, -1);
    // 1D, outer fields ignored (R6), 2-byte, negative inner step
    run(32'h0000_2000, 16'd5, 16'hFFFE, 16'd7, 16'd100, 6'b01_1100, 0, 100, 1, -1);
    // descriptor launch, 4-byte, outer step smaller than inner step
    run(32'h8000_0000, 16'd3, 16'd4, 16'd4, 16'd1, 6'b10_0101, 1, 80, 1, -1);

    // R11: launch requests during a handshake are dropped
    run(32'h0000_3000, 16'd4, 16'd2, 16'd2, 16'd1, 6'b00_0001, 1, 70, 1, 2);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    #1;
    chk(addr_o == 32'h0000_3000, "R11 shadow kept after ignored descriptor",
        addr_o, 32'h0000_3000);
    do_reset();

    // R8: circular, 2 rows of 3, both flags, 3 passes
    run(32'h0000_4000, 16'd3, 16'd1, 16'd2, 16'd10, 6'b00_1111, 0, 75, 3, -1);
    do_reset();

    // R5: inner count 0 means 65536 elements
    run(32'h0001_0000, 16'd0, 16'd1, 16'd0, 16'd0, 6'b00_1000, 0, 100, 1, -1);

    // R13: shadow write reaches the next launch; only base rewritten
    wr(3'd0, 32'h0000_5550);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    #1;
    chk(addr_o == 32'h0000_5550, "R13 rewritten base used", addr_o, 32'h0000_5550);
    do_reset();

    // constrained random mix
    for (int k = 0; k < 24; k++) begin
      logic [15:0] ic, oc, is, os;
      logic [5:0]  md;
      ic = 16'($urandom_range(1, 5));
      oc = 16'($urandom_range(1, 4));
      is = 16'($signed(int'($urandom_range(80)) - 40));
      os = 16'($signed(int'($urandom_range(80)) - 40));
      md = {2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)),
            1'b0, 1'($urandom_range(1))};
      run($urandom, ic, is, oc, os, md, bit'(k % 2), int'($urandom_range(30, 100)), 1, -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule